// File: doc/BRIEF.md
# Word-to-Byte External Bus Bridge

This block lets an on-chip bus initiator reach slow 8-bit parts such as boot ROM, flash and small peripheral chips. It acts as a target on a simplified PCI-like internal port. It claims an access when the bridge is enabled, the request comes from the local initiator, and the six most significant address bits match a programmed base field. Every 32-bit word on the upstream side is turned into exactly one single-byte access on a plain, non-multiplexed external bus. That bus has a 24-bit address, separate byte-wide data paths in each direction, a global chip select, read and write strobes, and a data strobe.

The external address is the word address of the upstream transfer. It is held in a counter that is loaded when the frame is accepted and that advances after every completed data phase, so a burst walks consecutive byte locations. On a write, only the top byte of the word is driven out. On a read, the word returned carries the byte fetched from the external bus in its top byte and the current external address in its low 24 bits. A wait-state count from 0 to 7 stretches every external access.

A five-state machine controls the bridge:
- IDLE: nothing claimed.
- CLAIMED: device-select is asserted and the bridge waits for initiator-ready.
- STROBE: the external strobes are active for 1 + wait-state cycles.
- ACK: target-ready is pulsed for one cycle.
- GAP: the bridge waits between data phases.

The transitions are:
- IDLE to CLAIMED on an accepted frame.
- CLAIMED or GAP to STROBE when initiator-ready is seen.
- CLAIMED or GAP to IDLE when the frame is dropped.
- STROBE to ACK when the wait timer is exhausted.
- ACK to GAP unconditionally.

Top module: `wbb_bridge`

## Requirements
- R1: When `cfg_enable` is 1, `up_local` is 1 and `up_addr[31:26]` equals `cfg_base` in the cycle where `up_frame` is seen in IDLE, `up_devsel` is 1 from the next cycle until the transfer ends.
- R2: If any of those three conditions fails, the bridge ignores the frame. `up_devsel`, `ext_cs`, `ext_rd`, `ext_wr`, `ext_ds` and `up_trdy` all stay 0.
- R3: `ext_cs` is 0 while the bridge waits in CLAIMED. It is 1 from the first strobe cycle of the first data phase until the transfer ends.
- R4: The first external address is `up_addr[25:2]` of the frame's starting address, so 0x44 in the low bits gives 0x000011.
- R5: The external address increases by one, modulo 2^24, after every completed data phase of a burst.
- R6: Each data phase produces exactly one external byte access, which is one contiguous run of `ext_ds`.
- R7: On a write, `ext_wr` is 1 and `ext_rd` is 0 during the strobe, and `ext_wdata` equals bits 31:24 of the phase's write word. Bits 23:0 of the word and `up_be` have no effect on the external bus.
- R8: On a read, `ext_rd` is 1 and `ext_wr` is 0 during the strobe. In the target-ready cycle, `up_rdata` equals `{byte sampled on the last strobe cycle, current 24-bit external address}`.
- R9: `ext_ds` and the active strobe last exactly 1 + `cfg_wait` cycles. `up_trdy` follows them as a single-cycle pulse.
- R10: If `up_frame` is 0 after a target-ready pulse, `ext_cs` and `up_devsel` return to 0 within two cycles and the bridge is ready for a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_enable | input | 1 | Bridge enable bit |
| cfg_base | input | 6 | Base compared with address bits 31:26 |
| cfg_wait | input | 3 | Wait states per external access |
| up_frame | input | 1 | Upstream frame, held for the whole transfer |
| up_local | input | 1 | 1 when the requester is the on-chip initiator |
| up_addr | input | 32 | Transfer start address, valid with frame start |
| up_write | input | 1 | 1 for write, 0 for read |
| up_irdy | input | 1 | Initiator ready |
| up_wdata | input | 32 | Write word |
| up_be | input | 4 | Byte enables (ignored) |
| up_devsel | output | 1 | Device select |
| up_trdy | output | 1 | Target ready pulse |
| up_rdata | output | 32 | Read word |
| ext_addr | output | 24 | External byte address |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | External read data |
| ext_cs | output | 1 | Global chip select |
| ext_rd | output | 1 | Read strobe |
| ext_wr | output | 1 | Write strobe |
| ext_ds | output | 1 | Data strobe |

## Verification
A corrupted state register shows up at once. Device-select or chip-select appears on an unclaimed frame or disappears in mid-burst within one cycle, and the strobe width or the target-ready pulse no longer matches 1 + wait states on the very phase where the fault occurs. A wrong address counter appears in the first read word that echoes the external address, or on `ext_addr` during the next strobe. A wrong latched byte appears on `ext_wdata` or in the top byte of `up_rdata` in that same phase. The sweep covers every wait count, both directions, burst lengths up to three, and wrap of the counter past 0xFFFFFF.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CLAIMED = 3'd1,
        ST_STROBE  = 3'd2,
        ST_ACK     = 3'd3,
        ST_GAP     = 3'd4
    } wbb_state_t;
endpackage

// File: rtl/wbb_decode.sv
module wbb_decode #(
    parameter int ADDR_W = 32,
    parameter int BASE_W = 6
) (
    input  logic              enable,
    input  logic              local_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] base,
    output logic              hit
);
    logic [BASE_W-1:0] top_bits;

    always_comb begin
        top_bits = addr[ADDR_W-1 -: BASE_W];
        hit      = enable && local_req && (top_bits == base);
    end
endmodule

// File: rtl/wbb_addr_ctr.sv
module wbb_addr_ctr #(
    parameter int CTR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CTR_W-1:0] load_val,
    input  logic             inc,
    output logic [CTR_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: one step per completed phase, wrapping at the counter width
    assert_ctr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (cnt == $past(cnt) + 1'b1));

    // R4: a load takes the word address unchanged
    assert_ctr_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/wbb_wait_timer.sv
module wbb_wait_timer #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              dec,
    output logic              zero
);
    logic [WAIT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (dec && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end

    always_comb zero = (remain == '0);

    // R9: the timer never wraps below zero
    assert_timer_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && zero) |=> zero);
endmodule

// File: rtl/wbb_bridge.sv
module wbb_bridge #(
    parameter int ADDR_W = 32,
    parameter int BASE_W = 6,
    parameter int WAIT_W = 3,
    parameter int EXT_AW = 24,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              up_frame,
    input  logic              up_local,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic              up_write,
    input  logic              up_irdy,
    input  logic [ADDR_W-1:0] up_wdata,
    input  logic [3:0]        up_be,
    output logic              up_devsel,
    output logic              up_trdy,
    output logic [ADDR_W-1:0] up_rdata,
    output logic [EXT_AW-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              ext_cs,
    output logic              ext_rd,
    output logic              ext_wr,
    output logic              ext_ds
);
    import wbb_pkg::*;

    localparam int WORD_LSB = 2;
    localparam int WORD_MSB = EXT_AW + WORD_LSB - 1;
    localparam int PAD_W    = ADDR_W - DATA_W - EXT_AW;

    wbb_state_t state, state_nx;

    logic              hit;
    logic              accept;
    logic              phase_go;
    logic              strobe_end;
    logic              timer_zero;
    logic              is_write;
    logic [DATA_W-1:0] wr_byte;
    logic [DATA_W-1:0] rd_byte;
    logic [EXT_AW-1:0] word_addr;
    logic [3:0]        be_unused;

    always_comb be_unused = up_be;

    wbb_decode #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_decode (
        .enable    (cfg_enable),
        .local_req (up_local),
        .addr      (up_addr),
        .base      (cfg_base),
        .hit       (hit)
    );

    always_comb begin
        accept     = (state == ST_IDLE) && up_frame && hit;
        phase_go   = ((state == ST_CLAIMED) || (state == ST_GAP)) && up_frame && up_irdy;
        strobe_end = (state == ST_STROBE) && timer_zero;
    end

    wbb_addr_ctr #(.CTR_W(EXT_AW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (up_addr[WORD_MSB:WORD_LSB]),
        .inc      (state == ST_ACK),
        .cnt      (word_addr)
    );

    wbb_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_go),
        .load_val (cfg_wait),
        .dec      (state == ST_STROBE),
        .zero     (timer_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (accept) state_nx = ST_CLAIMED;
            ST_CLAIMED: begin
                if (!up_frame)    state_nx = ST_IDLE;
                else if (up_irdy) state_nx = ST_STROBE;
            end
            ST_STROBE:  if (timer_zero) state_nx = ST_ACK;
            ST_ACK:     state_nx = ST_GAP;
            ST_GAP: begin
                if (!up_frame)    state_nx = ST_IDLE;
                else if (up_irdy) state_nx = ST_STROBE;
            end
            default:    state_nx = ST_IDLE;
        endcase
    end

    // datapath captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_write <= 1'b0;
            wr_byte  <= '0;
            rd_byte  <= '0;
        end else begin
            if (accept)     is_write <= up_write;
            if (phase_go)   wr_byte  <= up_wdata[ADDR_W-1 -: DATA_W];
            if (strobe_end) rd_byte  <= ext_rdata;
        end
    end

    // outputs
    always_comb begin
        up_devsel = 1'b0;
        up_trdy   = 1'b0;
        up_rdata  = '0;
        ext_cs    = 1'b0;
        ext_rd    = 1'b0;
        ext_wr    = 1'b0;
        ext_ds    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_CLAIMED: up_devsel = 1'b1;
            ST_STROBE: begin
                up_devsel = 1'b1;
                ext_cs    = 1'b1;
                ext_ds    = 1'b1;
                ext_rd    = !is_write;
                ext_wr    = is_write;
            end
            ST_ACK: begin
                up_devsel = 1'b1;
                ext_cs    = 1'b1;
                up_trdy   = 1'b1;
                up_rdata  = {rd_byte, {PAD_W{1'b0}}, word_addr};
            end
            ST_GAP: begin
                up_devsel = 1'b1;
                ext_cs    = 1'b1;
            end
            default: ;
        endcase
        ext_addr  = word_addr;
        ext_wdata = wr_byte;
    end

    // R2: an unmatched frame leaves the bridge idle
    assert_no_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && !hit) |=> !up_devsel);

    // R3: chip select only inside a claimed transfer
    assert_cs_in_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ext_cs |-> up_devsel);

    // R7: read and write strobes are exclusive
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_rd && ext_wr));

    // R9: target-ready is a single pulse that follows a strobe
    assert_trdy_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        up_trdy |=> !up_trdy);
    assert_trdy_after_ds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_trdy) |-> $past(ext_ds));

    // R10: dropping frame between phases returns to idle
    assert_end_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_GAP) && !up_frame) |=> !up_devsel);
endmodule

// File: tb/wbb_bridge_bench.sv
module wbb_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable;
    logic [5:0]  cfg_base;
    logic [2:0]  cfg_wait;
    logic        up_frame, up_local, up_write, up_irdy;
    logic [31:0] up_addr, up_wdata;
    logic [3:0]  up_be;
    logic        up_devsel, up_trdy;
    logic [31:0] up_rdata;
    logic [23:0] ext_addr;
    logic [7:0]  ext_wdata, ext_rdata;
    logic        ext_cs, ext_rd, ext_wr, ext_ds;

    int n_vec = 0;
    int n_bad = 0;
    localparam logic [5:0] BASE = 6'h2D;

    always #5 clk = ~clk;

    // external device model: byte is a function of the address
    always_comb ext_rdata = ext_addr[7:0] ^ ext_addr[15:8] ^ ext_addr[23:16] ^ 8'hA5;

    wbb_bridge u_wbb_bridge (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_base(cfg_base),
        .cfg_wait(cfg_wait), .up_frame(up_frame), .up_local(up_local),
        .up_addr(up_addr), .up_write(up_write), .up_irdy(up_irdy),
        .up_wdata(up_wdata), .up_be(up_be), .up_devsel(up_devsel),
        .up_trdy(up_trdy), .up_rdata(up_rdata), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_cs(ext_cs),
        .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_ds(ext_ds)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] dev_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    // claimed transfer of nw words with w wait states
    task automatic xfer(input logic [31:0] addr, input bit wr, input int nw, input int w, input int seed);
        logic [23:0] exp_a;
        logic [7:0]  exp_b;
        exp_a = addr[25:2];
        @(negedge clk);
        cfg_wait = 3'(w);
        up_frame = 1'b1; up_local = 1'b1; up_addr = addr; up_write = wr;
        up_irdy = 1'b1; up_be = 4'(seed);
        up_wdata = {8'(seed * 7 + 3), 24'(seed * 40503)};
        exp_b = up_wdata[31:24];
        @(negedge clk);
        check(up_devsel == 1'b1, "R1 devsel after claim", {31'd0, up_devsel}, 32'd1);
        check(ext_cs == 1'b0, "R3 cs low before data phase", {31'd0, ext_cs}, 32'd0);
        for (int k = 0; k < nw; k++) begin
            int  ds_cnt = 0;
            int  runs = 0;
            bit  done = 0;
            bit  prev_ds = 0;
            int  guard = 0;
            bit  strobe_ok = 1;
            while (!done && guard < 40) begin
                @(negedge clk);
                guard++;
                if (ext_ds) begin
                    ds_cnt++;
                    if (!prev_ds) runs++;
                    if (ext_addr != exp_a) strobe_ok = 0;
                    if (!ext_cs) strobe_ok = 0;
                    if (wr && (!ext_wr || ext_rd || ext_wdata != exp_b)) strobe_ok = 0;
                    if (!wr && (!ext_rd || ext_wr)) strobe_ok = 0;
                end else if (up_trdy) begin
                    done = 1;
                end
                prev_ds = ext_ds;
            end
            check(done, "R9 trdy reached", {31'd0, done}, 32'd1);
            check(ds_cnt == 1 + w, "R9 strobe length", 32'(ds_cnt), 32'(1 + w));
            check(runs == 1, "R6 one byte per word", 32'(runs), 32'd1);
            if (k == 0)
                check(strobe_ok, "R4 first address and strobes", {8'd0, ext_addr}, {8'd0, exp_a});
            else if (wr)
                check(strobe_ok, "R7 write byte, R5 address", {24'd0, ext_wdata}, {24'd0, exp_b});
            else
                check(strobe_ok, "R5 burst address, R8 read strobe", {8'd0, ext_addr}, {8'd0, exp_a});
            if (!wr)
                check(up_rdata == {dev_byte(exp_a), exp_a}, "R8 read word", up_rdata, {dev_byte(exp_a), exp_a});
            exp_a = exp_a + 24'd1;
            if (k == nw - 1) begin
                up_frame = 1'b0; up_irdy = 1'b0;
            end else begin
                up_wdata = {8'(seed * 13 + k * 29 + 1), 24'(k * 977 + seed)};
                up_be = ~up_be;
                exp_b = up_wdata[31:24];
            end
        end
        @(negedge clk);
        check(!up_trdy && ext_cs, "R9 trdy single pulse", {30'd0, up_trdy, ext_cs}, 32'd1);
        @(negedge clk);
        check(!ext_cs && !up_devsel, "R10 release after frame drop", {30'd0, ext_cs, up_devsel}, 32'd0);
    endtask

    // frame that must not be claimed
    task automatic miss(input logic [31:0] addr, input bit en, input bit loc, input string tag);
        bit quiet = 1;
        @(negedge clk);
        cfg_enable = en;
        up_frame = 1'b1; up_local = loc; up_addr = addr; up_irdy = 1'b1; up_write = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (up_devsel || ext_cs || ext_ds || ext_rd || ext_wr || up_trdy) quiet = 0;
        end
        check(quiet, tag, {31'd0, quiet}, 32'd1);
        up_frame = 1'b0; up_irdy = 1'b0; cfg_enable = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        cfg_enable = 1'b1; cfg_base = BASE; cfg_wait = 3'd0;
        up_frame = 1'b0; up_local = 1'b1; up_addr = '0; up_write = 1'b0;
        up_irdy = 1'b0; up_wdata = '0; up_be = '0;
        repeat (3) @(negedge clk);
        check(!up_devsel && !ext_cs && !ext_ds && !up_trdy, "R2 reset state quiet",
              {28'd0, up_devsel, ext_cs, ext_ds, up_trdy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // word address of 0x44 is 0x11 (R4)
        xfer({BASE, 26'h44}, 1'b0, 1, 0, 1);
        for (int w = 0; w < 8; w++)
            for (int d = 0; d < 2; d++)
                for (int n = 1; n <= 3; n++)
                    xfer({BASE, 26'(w * 1234567 + n * 4099 + d * 64)}, d[0], n, w, w * 6 + d * 3 + n);
        // counter wrap past 0xFFFFFF (R5)
        xfer({BASE, 26'h3FFFFF8}, 1'b0, 3, 2, 77);
        xfer({BASE, 26'h3FFFFFC}, 1'b1, 2, 5, 78);
        // ignored accesses (R2)
        miss({BASE, 26'h100}, 1'b0, 1'b1, "R2 disabled bridge");
        miss({BASE ^ 6'h01, 26'h100}, 1'b1, 1'b1, "R2 base mismatch low bit");
        miss({BASE ^ 6'h20, 26'h100}, 1'b1, 1'b1, "R2 base mismatch high bit");
        miss({BASE, 26'h100}, 1'b1, 1'b0, "R2 external master");
        // claim still works after ignored frames (R10)
        xfer({BASE, 26'h2000}, 1'b1, 2, 7, 91);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule